// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM from power-on to a state where it accepts normal commands. After reset is released it raises the clock enable and holds the command bus idle (deselected) for a power-up delay. It then issues a precharge to every bank, two auto-refresh commands and a mode-register load. The mode-register load can come either after the refresh pair or before it, as an elaboration option. Each gap between commands is a cycle count. That count is the ceiling of a picosecond timing parameter divided by the clock period, computed at elaboration.

When the last gap has run out, a sticky `init_done_o` rises. After that, a downstream controller may drive the memory. While initialization is in progress, DQM is held high so the data pins stay high-impedance. After completion the sequencer leaves the bus deselected.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low: `cke_o`=0; the bus is deselected ({cs_n,ras_n,cas_n,we_n}=4'b1111); `addr_o`=0; `ba_o`=0; every `dqm_o` bit is 1; `init_done_o`=0.
- R2: `cke_o` goes high at the first rising edge after reset release and stays high until the next reset.
- R3: No command other than deselect appears before the precharge. The precharge appears after exactly PU_CYC rising edges following reset release, with PU_CYC = max(2, ceil(PWRUP_PS/TCK_PS)).
- R4: The precharge is encoded {cs_n,ras_n,cas_n,we_n}=4'b0010. During it, `addr_o` has only bit AP_BIT (default 10) set and `ba_o`=0.
- R5: Auto-refresh is encoded 4'b0001 and is issued exactly twice. The command after the precharge comes TRP_CYC=ceil(TRP_PS/TCK_PS) edges later. The command after each refresh comes TRFC_CYC=ceil(TRFC_PS/TCK_PS) edges later.
- R6: The mode-register load is encoded 4'b0000. It drives `addr_o`=MODE_CODE with its top bit forced to 0, and `ba_o`=MODE_BA. The next event comes TMRD_CYC edges later.
- R7: With MODE_FIRST=0 the order is precharge, refresh, refresh, load. With MODE_FIRST=1 it is precharge, load, refresh, refresh.
- R8: `init_done_o` rises exactly one gap after the last command: TMRD_CYC edges after the load (MODE_FIRST=0), or TRFC_CYC edges after the second refresh (MODE_FIRST=1). It then stays high until reset.
- R9: Each command lasts one cycle. Every other cycle is deselect, including every cycle after `init_done_o` is high. `addr_o` and `ba_o` are 0 on deselect cycles.
- R10: `dqm_o` is all ones until `init_done_o` rises and all zeros afterwards.
- R11: A reset asserted part-way through the sequence returns all outputs to the R1 state at once. The next release restarts the full sequence from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/address bus |
| dqm_o | output | DQM_W | Data mask, held high during init |
| init_done_o | output | 1 | Sticky initialization-complete flag |

## Verification
The bench compares every output on every cycle against a schedule computed from the timing parameters. It runs two configurations side by side, one with each load ordering and with different clock periods. This exposes an off-by-one in any gap, since a counter that loads N instead of N-1 shifts every later command by one cycle. A non-integer power-up ratio catches a floor instead of a ceiling. A mode code whose top bit is set shows whether the bit is cleared during the load. Resets are asserted at random points mid-sequence, which catches state such as the step index or the done flag that survives reset, and catches a done flag that rises early or falls again.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_DESL = 4'b1111
  } cmd_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_step.sv
module sdram_init_step
  import sdram_init_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TRP_CYC    = 2,
  parameter int TRFC_CYC   = 2,
  parameter int MR_CYC     = 2,
  parameter bit MODE_FIRST = 1'b0
) (
  input  logic [2:0]       step_i,
  output cmd_e             cmd_o,
  output logic [CNT_W-1:0] gap_o
);
  // gaps stored as cycles-1: the timer counts down to zero
  localparam logic [CNT_W-1:0] G_RP  = CNT_W'(TRP_CYC - 1);
  localparam logic [CNT_W-1:0] G_RFC = CNT_W'(TRFC_CYC - 1);
  localparam logic [CNT_W-1:0] G_MR  = CNT_W'(MR_CYC - 1);

  if (MODE_FIRST) begin : g_mode_first
    always_comb begin
      cmd_o = CMD_DESL;
      gap_o = '0;
      case (step_i)
        3'd0: begin cmd_o = CMD_PRE; gap_o = G_RP;  end
        3'd1: begin cmd_o = CMD_LMR; gap_o = G_MR;  end
        3'd2: begin cmd_o = CMD_REF; gap_o = G_RFC; end
        3'd3: begin cmd_o = CMD_REF; gap_o = G_RFC; end
        default: ;
      endcase
    end
  end else begin : g_mode_last
    always_comb begin
      cmd_o = CMD_DESL;
      gap_o = '0;
      case (step_i)
        3'd0: begin cmd_o = CMD_PRE; gap_o = G_RP;  end
        3'd1: begin cmd_o = CMD_REF; gap_o = G_RFC; end
        3'd2: begin cmd_o = CMD_REF; gap_o = G_RFC; end
        3'd3: begin cmd_o = CMD_LMR; gap_o = G_MR;  end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int TCK_PS     = 7500,
  parameter int PWRUP_PS   = 100_000_000,
  parameter int TRP_PS     = 20_000,
  parameter int TRFC_PS    = 66_000,
  parameter int TMRD_CYC   = 2,
  parameter bit MODE_FIRST = 1'b0,
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int DQM_W      = 2,
  parameter int AP_BIT     = 10,
  parameter logic [ADDR_W-1:0] MODE_CODE = ADDR_W'(32'h0032),
  parameter logic [BA_W-1:0]   MODE_BA   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              init_done_o
);
  localparam int PU_CYC   = max2(2, ceil_div(PWRUP_PS, TCK_PS));
  localparam int TRP_CYC  = max2(1, ceil_div(TRP_PS, TCK_PS));
  localparam int TRFC_CYC = max2(1, ceil_div(TRFC_PS, TCK_PS));
  localparam int MR_CYC   = max2(1, TMRD_CYC);
  localparam int MAX_CYC  = max2(max2(PU_CYC, TRP_CYC), max2(TRFC_CYC, MR_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [2:0] LAST_STEP = 3'd4;
  localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] TOP_MASK = ADDR_W'(1) << (ADDR_W - 1);

  logic [2:0]        step_q;
  logic              done_q, cke_q;
  cmd_e              cmd_q, step_cmd;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [BA_W-1:0]   ba_q, nxt_ba;
  logic [CNT_W-1:0]  step_gap;
  logic              tmr_zero, fire, tmr_load;

  sdram_init_step #(
    .CNT_W(CNT_W), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .MR_CYC(MR_CYC), .MODE_FIRST(MODE_FIRST)
  ) u_step (
    .step_i(step_q), .cmd_o(step_cmd), .gap_o(step_gap)
  );

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(PU_CYC - 1)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .val_i(step_gap), .zero_o(tmr_zero)
  );

  assign fire     = tmr_zero & ~done_q;
  assign tmr_load = fire & (step_q != LAST_STEP);

  always_comb begin
    nxt_addr = '0;
    nxt_ba   = '0;
    case (step_cmd)
      CMD_PRE: nxt_addr = AP_MASK;
      CMD_LMR: begin
        nxt_addr = MODE_CODE & ~TOP_MASK;
        nxt_ba   = MODE_BA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      done_q <= 1'b0;
      cke_q  <= 1'b0;
      cmd_q  <= CMD_DESL;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_DESL;
      addr_q <= '0;
      ba_q   <= '0;
      if (fire) begin
        if (step_q == LAST_STEP) begin
          done_q <= 1'b1;
        end else begin
          cmd_q  <= step_cmd;
          addr_q <= nxt_addr;
          ba_q   <= nxt_ba;
          step_q <= step_q + 3'd1;
        end
      end
    end
  end

  assign cke_o = cke_q;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign addr_o = addr_q;
  assign ba_o   = ba_q;
  assign dqm_o  = {DQM_W{~done_q}};
  assign init_done_o = done_q;

  a_r2_cke_before_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != CMD_DESL) |-> cke_o);
  a_r4_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> addr_o[AP_BIT]);
  a_r6_lmr_top_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_LMR) |-> !addr_o[ADDR_W-1]);
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r9_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cmd_q == CMD_DESL && addr_o == '0));
  a_r3_no_cmd_before_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == 3'd0) |-> (cmd_q == CMD_DESL));
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int CLK_PERIOD = 10;

  // config A: load after refresh pair
  localparam int A_TCK = 7500, A_PWR = 1_000_000, A_TRP = 20_000, A_TRFC = 66_000, A_MRD = 2;
  localparam logic [12:0] A_CODE = 13'h1A37;
  localparam logic [1:0]  A_BA   = 2'b01;
  // config B: load before refresh pair
  localparam int B_TCK = 10_000, B_PWR = 500_000, B_TRP = 15_000, B_TRFC = 66_000, B_MRD = 3;
  localparam logic [12:0] B_CODE = 13'h0022;
  localparam logic [1:0]  B_BA   = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba, a_dqm;
  logic [12:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba, b_dqm;
  logic [12:0] b_addr;

  sdram_init_seq #(
    .TCK_PS(A_TCK), .PWRUP_PS(A_PWR), .TRP_PS(A_TRP), .TRFC_PS(A_TRFC),
    .TMRD_CYC(A_MRD), .MODE_FIRST(1'b0), .MODE_CODE(A_CODE), .MODE_BA(A_BA)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(a_cke), .cs_n_o(a_cs), .ras_n_o(a_ras),
    .cas_n_o(a_cas), .we_n_o(a_we), .ba_o(a_ba), .addr_o(a_addr), .dqm_o(a_dqm),
    .init_done_o(a_done)
  );

  sdram_init_seq #(
    .TCK_PS(B_TCK), .PWRUP_PS(B_PWR), .TRP_PS(B_TRP), .TRFC_PS(B_TRFC),
    .TMRD_CYC(B_MRD), .MODE_FIRST(1'b1), .MODE_CODE(B_CODE), .MODE_BA(B_BA)
  ) uut_mf (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(b_cke), .cs_n_o(b_cs), .ras_n_o(b_ras),
    .cas_n_o(b_cas), .we_n_o(b_we), .ba_o(b_ba), .addr_o(b_addr), .dqm_o(b_dqm),
    .init_done_o(b_done)
  );

  int checks = 0;
  int errors = 0;

  function automatic int cdiv(input int n, input int d);
    int q;
    q = n / d;
    if (q * d < n) q++;
    return q;
  endfunction

  function automatic logic [3:0] exp_cmd(input int pu, input int trp, input int trfc,
                                         input int mrd, input bit mf, input int k);
    int t;
    t = pu;
    if (k == t) return 4'h2;
    t += trp;
    if (mf) begin
      if (k == t) return 4'h0;
      t += mrd;
      if (k == t) return 4'h1;
      t += trfc;
      if (k == t) return 4'h1;
    end else begin
      if (k == t) return 4'h1;
      t += trfc;
      if (k == t) return 4'h1;
      t += trfc;
      if (k == t) return 4'h0;
    end
    return 4'hF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_one(input string nm, input int tck, input int pwr, input int trp_ps,
                           input int trfc_ps, input int mrd, input bit mf,
                           input logic [12:0] code, input logic [1:0] mba, input int k,
                           input logic cke, input logic [3:0] cmd, input logic [12:0] addr,
                           input logic [1:0] ba, input logic [1:0] dqm, input logic done);
    int pu, trp, trfc, total;
    logic [3:0] ec;
    logic [12:0] ea;
    logic [1:0] eb;
    string tag;
    pu    = cdiv(pwr, tck);
    if (pu < 2) pu = 2;
    trp   = cdiv(trp_ps, tck);
    trfc  = cdiv(trfc_ps, tck);
    total = pu + trp + 2 * trfc + mrd;
    ec = exp_cmd(pu, trp, trfc, mrd, mf, k);
    ea = 13'h0;
    eb = 2'b00;
    case (ec)
      4'h2: begin tag = "R4"; ea = 13'h0400; end
      4'h1: tag = "R5";
      4'h0: begin tag = "R6"; ea = code & 13'h0FFF; eb = mba; end
      default: tag = (k < pu) ? "R3" : "R9";
    endcase
    if (mf && ec != 4'hF) tag = {tag, "/R7"};
    check({nm, " cmd ", tag}, 32'(cmd), 32'(ec));
    check({nm, " addr ", tag}, 32'(addr), 32'(ea));
    check({nm, " ba ", tag}, 32'(ba), 32'(eb));
    check({nm, " R2 cke"}, 32'(cke), 32'(k >= 1));
    check({nm, " R8 done"}, 32'(done), 32'(k >= total));
    check({nm, " R10 dqm"}, 32'(dqm), (k >= total) ? 32'h0 : 32'h3);
  endtask

  task automatic check_reset(input string tag);
    check({tag, " A cke"}, 32'(a_cke), 32'h0);
    check({tag, " A bus"}, 32'({a_cs, a_ras, a_cas, a_we}), 32'hF);
    check({tag, " A addr/ba"}, 32'({a_addr, a_ba}), 32'h0);
    check({tag, " A dqm/done"}, 32'({a_dqm, a_done}), 32'h6);
    check({tag, " B cke"}, 32'(b_cke), 32'h0);
    check({tag, " B bus"}, 32'({b_cs, b_ras, b_cas, b_we}), 32'hF);
    check({tag, " B addr/ba"}, 32'({b_addr, b_ba}), 32'h0);
    check({tag, " B dqm/done"}, 32'({b_dqm, b_done}), 32'h6);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check_one("A", A_TCK, A_PWR, A_TRP, A_TRFC, A_MRD, 1'b0, A_CODE, A_BA, k,
                a_cke, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_dqm, a_done);
      check_one("B", B_TCK, B_PWR, B_TRP, B_TRFC, B_MRD, 1'b1, B_CODE, B_BA, k,
                b_cke, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_dqm, b_done);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int abort_at;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_reset("R1");
    // directed: abort right as precharge of config B would issue, then full run
    run(50);
    rst_n = 1'b0;
    #1 check_reset("R11");
    repeat (2) @(negedge clk);
    run(190);
    rst_n = 1'b0;
    #1 check_reset("R1");
    for (int it = 0; it < 5; it++) begin
      abort_at = int'($urandom_range(5, 165));
      repeat (int'($urandom_range(1, 4))) @(negedge clk);
      run(abort_at);
      rst_n = 1'b0;
      #1 check_reset("R11");
      repeat (int'($urandom_range(1, 4))) @(negedge clk);
      run(190);
      rst_n = 1'b0;
      #1 check_reset("R1");
    end
    finish_run();
  end
endmodule